// File: doc/BRIEF.md
# Carry-Tracking Lane-Local Vector Adder

The block adds two vectors lane by lane. No carry crosses a lane boundary, so every lane wraps its result modulo 2^N. The carry that is dropped is not lost. Each lane keeps a small carry state element in which it records it, so a separate resolution stage can settle the carries later, after several additions. This keeps the per-lane datapath short and independent of the lane count.

Each lane's carry state element holds two 4-bit fields. The first counts the carry-outs the lane has produced so far in the current chain. The second says how many incoming carries the lane's present result can absorb before it would overflow itself. To accumulate, feed the carry state vector out of one addition back in with the next one. Assert `clear` on the first addition of a chain. Resolve the carries before the count can pass 15. From a cleared start, fifteen carry-producing additions fit and the sixteenth does not.

The results are registered: they appear one clock after the operands are presented.

Top module: `cta_vec_adder`

## Requirements
- R1: Lane i of `sum_out` (bits [i*N +: N]) equals (lane i of `op_a` + lane i of `op_b`) mod 2^N. A carry out of lane i has no effect on any other lane.
- R2: Carry state element i sits at bits [i*8 +: 8] of `cs_in` and `cs_out`, with the carry-out count in bits [3:0]. When `clear` is low, the outgoing count equals the incoming count plus one if the lane's addition carries out, and the incoming count otherwise.
- R3: When `clear` is high, the incoming counts are treated as zero. Each outgoing count is then 1 if its lane carries out and 0 otherwise.
- R4: The absorb-limit field, bits [7:4] of each element, equals min(15, 2^N − 1 − lane sum). It ignores the incoming limit field.
- R5: `ovf_out` is high when at least one lane carries out while its effective incoming count is already 15. That lane's outgoing count then stays at 15.
- R6: All outputs are registered, one clock after the inputs. While `rst_n` is low, every output is zero.
- R7: Starting from `clear` with a carry on every addition and the state fed back, the first 15 additions leave `ovf_out` low and the 15th leaves the count at 15. The 16th raises `ovf_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Start a new chain; incoming counts read as zero |
| op_a | input | LANES*N | First operand vector |
| op_b | input | LANES*N | Second operand vector |
| cs_in | input | LANES*8 | Incoming carry state vector |
| sum_out | output | LANES*N | Lane-wise wrapped sums |
| cs_out | output | LANES*8 | Updated carry state vector |
| ovf_out | output | 1 | Some lane's carry-out count overflowed |

## Verification
The assertions check on every cycle the relations that tie the outputs to the previous cycle's inputs:
- each lane's wrapped sum;
- the count stepping by zero or one;
- the count after a clear never exceeding one;
- the absorb limit matching the registered sum;
- an overflow flag always coming with a saturated lane.

Only the bench's scenarios can show the rest:
- exact counts under mixed clear patterns;
- the boundary where the fifteenth chained carry is accepted and the sixteenth overflows;
- the limit corners at sums 0xF0, 0xF1 and 0xFF;
- the outputs holding still between a new drive and the next edge.

// File: rtl/cta_pkg.sv
package cta_pkg;
   localparam int CTA_FW   = 4;
   localparam int CTA_FMAX = (1 << CTA_FW) - 1;

   typedef struct packed {
      logic [CTA_FW-1:0] lim;
      logic [CTA_FW-1:0] cnt;
   } cta_state_t;

   localparam int CTA_SW = $bits(cta_state_t);
endpackage

// File: rtl/cta_limit.sv
module cta_limit
   import cta_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]      sum,
   output logic [CTA_FW-1:0] lim
);
   logic [N-1:0] headroom;

   assign headroom = ~sum;

   generate
      if (N < 1) begin : g_bad
         $error("cta_limit: N must be at least 1");
      end
      if (N > CTA_FW) begin : g_sat
         always_comb begin
            if (|headroom[N-1:CTA_FW]) lim = CTA_FW'(CTA_FMAX);
            else                       lim = headroom[CTA_FW-1:0];
         end
      end else if (N == CTA_FW) begin : g_eq
         assign lim = headroom;
      end else begin : g_narrow
         assign lim = {{(CTA_FW-N){1'b0}}, headroom};
      end
   endgenerate
endmodule

// File: rtl/cta_lane.sv
module cta_lane
   import cta_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  cta_state_t   st_in,
   input  logic         clear,
   output logic [N-1:0] sum,
   output cta_state_t   st_out,
   output logic         ovf
);
   logic              cy;
   logic [CTA_FW-1:0] cnt_base;
   logic [CTA_FW-1:0] lim_new;

   assign {cy, sum} = {1'b0, a} + {1'b0, b};
   assign cnt_base  = clear ? '0 : st_in.cnt;
   assign ovf       = cy & (cnt_base == CTA_FW'(CTA_FMAX));

   cta_limit #(.N(N)) u_limit (
      .sum (sum),
      .lim (lim_new)
   );

   always_comb begin
      st_out.lim = lim_new;
      if (ovf) st_out.cnt = CTA_FW'(CTA_FMAX);
      else     st_out.cnt = cnt_base + {{(CTA_FW-1){1'b0}}, cy};
   end
endmodule

// File: rtl/cta_vec_adder.sv
module cta_vec_adder
   import cta_pkg::*;
#(
   parameter int LANES = 4,
   parameter int N     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic [LANES*N-1:0]       op_a,
   input  logic [LANES*N-1:0]       op_b,
   input  logic [LANES*CTA_SW-1:0]  cs_in,
   output logic [LANES*N-1:0]       sum_out,
   output logic [LANES*CTA_SW-1:0]  cs_out,
   output logic                     ovf_out
);
   localparam int VW = LANES * N;
   localparam int SW = LANES * CTA_SW;

   logic [VW-1:0]    sum_d;
   logic [SW-1:0]    cs_d;
   logic [LANES-1:0] ovf_lane;
   logic [LANES-1:0] sat_lane;
   logic             seen_q;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("cta_vec_adder: LANES must be at least 1");
      end
      if (N < 1) begin : g_bad_n
         $error("cta_vec_adder: N must be at least 1");
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         cta_state_t st_i, st_o;
         assign st_i = cs_in[i*CTA_SW +: CTA_SW];
         assign cs_d[i*CTA_SW +: CTA_SW] = st_o;

         cta_lane #(.N(N)) u_lane (
            .a      (op_a[i*N +: N]),
            .b      (op_b[i*N +: N]),
            .st_in  (st_i),
            .clear  (clear),
            .sum    (sum_d[i*N +: N]),
            .st_out (st_o),
            .ovf    (ovf_lane[i])
         );

         cta_state_t st_q;
         logic [N-1:0] hd_q;
         assign st_q = cs_out[i*CTA_SW +: CTA_SW];
         assign hd_q = ~sum_out[i*N +: N];
         assign sat_lane[i] = (st_q.cnt == CTA_FW'(CTA_FMAX));

         // R1: wrapped lane sum, no neighbour influence
         assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> (sum_out[i*N +: N] ==
                        N'($past(op_a[i*N +: N]) + $past(op_b[i*N +: N]))));

         // R2: count advances by zero or one when not cleared
         assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && !$past(clear) && !ovf_out) |->
               ((st_q.cnt == $past(cs_in[i*CTA_SW +: CTA_FW])) ||
                (st_q.cnt == $past(cs_in[i*CTA_SW +: CTA_FW]) + 4'd1)));

         // R3: cleared chain restarts from zero
         assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $past(clear)) |-> (st_q.cnt <= 4'd1));

         // R4: limit field follows the registered sum
         assert_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> ((hd_q > N'(CTA_FMAX)) ? (st_q.lim == CTA_FW'(CTA_FMAX))
                                              : (N'(st_q.lim) == hd_q)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_out <= '0;
         cs_out  <= '0;
         ovf_out <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         sum_out <= sum_d;
         cs_out  <= cs_d;
         ovf_out <= |ovf_lane;
         seen_q  <= 1'b1;
      end
   end

   // R5: an overflow flag always comes with a saturated lane
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_out |-> (|sat_lane));
endmodule

// File: tb/cta_vec_adder_test.sv
module cta_vec_adder_test;
   localparam int LANES = 4;
   localparam int N     = 8;
   localparam int VW    = LANES * N;
   localparam int SW    = LANES * 8;
   localparam int MAXV  = (1 << N) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic [VW-1:0] op_a = '0;
   logic [VW-1:0] op_b = '0;
   logic [SW-1:0] cs_in = '0;
   logic [VW-1:0] sum_out;
   logic [SW-1:0] cs_out;
   logic          ovf_out;

   int total = 0;
   int bad   = 0;
   bit have_exp = 0;
   bit exp_clr;
   int exp_sum [LANES];
   int exp_cnt [LANES];
   int exp_lim [LANES];
   int exp_ovf;

   always #5 clk = ~clk;

   cta_vec_adder #(.LANES(LANES), .N(N)) uut (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .op_a(op_a), .op_b(op_b), .cs_in(cs_in),
      .sum_out(sum_out), .cs_out(cs_out), .ovf_out(ovf_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare();
      if (!have_exp) return;
      for (int l = 0; l < LANES; l++) begin
         int gs, gc, gl;
         gs = int'(sum_out[l*N +: N]);
         gc = int'(cs_out[l*8 +: 4]);
         gl = int'(cs_out[l*8+4 +: 4]);
         chk(gs == exp_sum[l], "R1", $sformatf("sum lane %0d", l), gs, exp_sum[l]);
         chk(gc == exp_cnt[l], exp_clr ? "R3" : "R2",
             $sformatf("count lane %0d", l), gc, exp_cnt[l]);
         chk(gl == exp_lim[l], "R4", $sformatf("limit lane %0d", l), gl, exp_lim[l]);
      end
      chk(int'(ovf_out) == exp_ovf, "R5", "overflow flag", int'(ovf_out), exp_ovf);
   endtask

   // called at a falling edge: check previous result, drive and predict next
   task automatic step(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [SW-1:0] cs, input logic clr);
      logic [VW-1:0] held;
      compare();
      held  = sum_out;
      op_a  = a;
      op_b  = b;
      cs_in = cs;
      clear = clr;
      exp_clr = clr;
      exp_ovf = 0;
      for (int l = 0; l < LANES; l++) begin
         int s, cy, base;
         s    = int'(a[l*N +: N]) + int'(b[l*N +: N]);
         cy   = s >> N;
         s    = s & MAXV;
         base = clr ? 0 : int'(cs[l*8 +: 4]);
         if (cy == 1 && base == 15) begin
            exp_ovf    = 1;
            exp_cnt[l] = 15;
         end else begin
            exp_cnt[l] = base + cy;
         end
         exp_sum[l] = s;
         exp_lim[l] = (MAXV - s > 15) ? 15 : MAXV - s;
      end
      have_exp = 1;
      #1;
      chk(sum_out == held, "R6", "output moved before clock edge",
          int'(sum_out), int'(held));
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      op_a  = '1;
      op_b  = '1;
      cs_in = '1;
      clear = 1'b0;
      repeat (3) @(negedge clk);
      // R6: reset state
      chk(sum_out == '0, "R6", "sum in reset", int'(sum_out), 0);
      chk(cs_out == '0, "R6", "state in reset", int'(cs_out), 0);
      chk(ovf_out == 1'b0, "R6", "ovf in reset", int'(ovf_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 corners and R1 lane isolation: lanes FF+01, F0+00, F1+00, 7F+80
      step(32'h7F_F1_F0_FF, 32'h80_00_00_01, 32'hA5_A5_A5_A5, 1'b0);
      step(32'h80_FF_00_FF, 32'h80_00_00_FF, 32'h5F_00_FF_3C, 1'b1);

      // R7: chained carries on every lane from a cleared start
      step({LANES{8'hFF}}, {LANES{8'hFF}}, '0, 1'b1);
      for (int k = 2; k <= 16; k++) begin
         if (k == 16) begin
            compare();
            chk(ovf_out == 1'b0, "R7", "no overflow after 15 additions", int'(ovf_out), 0);
            chk(int'(cs_out[3:0]) == 15, "R7", "count after 15 additions",
                int'(cs_out[3:0]), 15);
         end
         step({LANES{8'hFF}}, {LANES{8'hFF}}, cs_out, 1'b0);
      end
      compare();
      have_exp = 0;
      chk(ovf_out == 1'b1, "R7", "overflow on 16th addition", int'(ovf_out), 1);

      // mixed random traffic with occasional clears and feedback
      for (int k = 0; k < 300; k++) begin
         logic [SW-1:0] cs;
         cs = (k % 3 == 0) ? cs_out : SW'($urandom);
         step(VW'($urandom), VW'($urandom), cs, ($urandom % 5) == 0);
      end
      compare();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule